// File: doc/BRIEF.md
# Cell Transmit Clock-Crossing FIFO

This block carries fixed-size cells from a fast fabric-side clock into a slower framer clock. Every cycle that the writer has data, it presents a 32-bit word together with two marker bits. The first marker flags the first word of a cell. The second flags words that belong to filler cells generated inside the chip. The writer gets no ready or acknowledge signal back. The storage must therefore always have room for one cell being written while another is being drained. The block has 64 entries, and a cell is at most 23 words long.

The reader is a frame builder. It sees the word at the head of the queue, with both marker bits, at all times (first-word fall-through). It takes the word by pulsing a pop strobe. Each side keeps its own binary pointer and passes it to the other side as a Gray code through a two-flop synchronizer. A reader-side cell-ready indication tells the frame builder when a complete cell is waiting at the head. Sticky error flags record any write into a full queue and any read from an empty one. Each flag lives in its own domain.

Top module: `cell_xfer_fifo`

## Requirements
- R1: After reset, empty is 1, while full, the overflow flag, the underrun flag and cell_ready are 0, and rd_count is 0.
- R2: Words leave in the order they were written, with all fields intact: the 32 data bits, the start-of-cell marker (stored bit 32) and the idle-cell marker (stored bit 33).
- R3: full rises once 64 words have been accepted and not yet read. A write while full is dropped and sets the sticky overflow flag, which only reset clears.
- R4: A pop while empty leaves the read pointer where it is and sets the sticky underrun flag, which only reset clears.
- R5: rd_count reports the number of stored words seen by the reader, from 0 to 64, and empty is 1 exactly when it is 0.
- R6: cell_ready is 1 exactly when the queue is not empty, the head word has its start-of-cell marker set, and rd_count is at least 23.
- R7: Reading a word from a full queue frees space, and full falls within a few write-clock cycles.
- R8: Asserting reset in both domains clears both sticky flags and empties the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write (fabric) clock |
| wrst_n | input | 1 | Write-domain asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data word |
| wr_soc | input | 1 | Start-of-cell marker for the word |
| wr_idle | input | 1 | Idle-cell marker for the word |
| full | output | 1 | Queue full, write domain |
| wr_overflow | output | 1 | Sticky: a write was attempted while full |
| rclk | input | 1 | Read (framer) clock |
| rrst_n | input | 1 | Read-domain asynchronous reset, active low |
| rd_en | input | 1 | Pop strobe |
| rd_data | output | 32 | Head data word |
| rd_soc | output | 1 | Head start-of-cell marker |
| rd_idle | output | 1 | Head idle-cell marker |
| empty | output | 1 | Queue empty, read domain |
| rd_count | output | 7 | Stored words as seen by the reader |
| rd_underrun | output | 1 | Sticky: a pop was attempted while empty |
| cell_ready | output | 1 | A whole cell starts at the head |

## Verification
A corrupted read pointer shows up immediately on the head word and its markers. It also shows in rd_count on the same read-clock cycle, so the bench compares every popped word against the written sequence.

A wrong pointer crossing in either direction shows up after the two-flop synchronizer delay. It appears as a wrong rd_count or a full flag that never rises or never falls. The bench checks both after a settling interval of a few cycles in each domain.

A dropped or mis-set sticky flag is visible on its port one cycle after the offending strobe. An overflowing write that is wrongly accepted corrupts the oldest words, which is caught when the 64 entries are drained.

// File: rtl/cxf_pkg.sv
package cxf_pkg;
  localparam int DATA_W = 32;

  typedef struct packed {
    logic              idle;
    logic              soc;
    logic [DATA_W-1:0] data;
  } cxf_word_t;

  localparam int WORD_W = $bits(cxf_word_t);
endpackage

// File: rtl/cxf_rst_sync.sv
module cxf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/cxf_gray_sync.sv
module cxf_gray_sync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/cxf_mem.sv
module cxf_mem #(
  parameter int AW = 6,
  parameter int W  = 34
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] ram [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) ram[waddr] <= wdata;
  end

  assign rdata = ram[raddr];
endmodule

// File: rtl/cxf_wr_ctl.sv
module cxf_wr_ctl #(
  parameter int AW = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push,
  input  logic [AW:0] rgray_s,
  output logic [AW-1:0] waddr,
  output logic [AW:0] wgray,
  output logic        we,
  output logic        full,
  output logic        overflow
);
  logic [AW:0] bin_q, bin_d, gray_q, gray_d;
  logic        ovf_q, ovf_d;
  logic        ptr_en, ovf_en;

  always_comb begin
    full   = (gray_q == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
    ptr_en = push & ~full;
    ovf_en = push & full;
    bin_d  = bin_q + 1'b1;
    gray_d = bin_d ^ (bin_d >> 1);
    ovf_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else if (ptr_en) begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ovf_q <= 1'b0;
    else if (ovf_en) ovf_q <= ovf_d;
  end

  assign waddr    = bin_q[AW-1:0];
  assign wgray    = gray_q;
  assign we       = ptr_en;
  assign overflow = ovf_q;
endmodule

// File: rtl/cxf_rd_ctl.sv
module cxf_rd_ctl #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  input  logic [AW:0]   wgray_s,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [AW:0]   count,
  output logic          empty,
  output logic          underrun
);
  logic [AW:0] bin_q, bin_d, gray_q, gray_d, wbin_s;
  logic        unf_q, ptr_en, unf_en;

  always_comb begin
    for (int i = 0; i <= AW; i++) wbin_s[i] = ^(wgray_s >> i);
    count  = wbin_s - bin_q;
    empty  = (count == '0);
    ptr_en = pop & ~empty;
    unf_en = pop & empty;
    bin_d  = bin_q + 1'b1;
    gray_d = bin_d ^ (bin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else if (ptr_en) begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      unf_q <= 1'b0;
    else if (unf_en) unf_q <= 1'b1;
  end

  assign raddr    = bin_q[AW-1:0];
  assign rgray    = gray_q;
  assign underrun = unf_q;
endmodule

// File: rtl/cell_xfer_fifo.sv
module cell_xfer_fifo #(
  parameter int ADDR_W     = 6,
  parameter int CELL_WORDS = 23
) (
  input  logic                      wclk,
  input  logic                      wrst_n,
  input  logic                      wr_en,
  input  logic [cxf_pkg::DATA_W-1:0] wr_data,
  input  logic                      wr_soc,
  input  logic                      wr_idle,
  output logic                      full,
  output logic                      wr_overflow,
  input  logic                      rclk,
  input  logic                      rrst_n,
  input  logic                      rd_en,
  output logic [cxf_pkg::DATA_W-1:0] rd_data,
  output logic                      rd_soc,
  output logic                      rd_idle,
  output logic                      empty,
  output logic [ADDR_W:0]           rd_count,
  output logic                      rd_underrun,
  output logic                      cell_ready
);
  import cxf_pkg::*;

  localparam int PTR_W = ADDR_W + 1;
  localparam logic [PTR_W-1:0] CELL_TH = PTR_W'(CELL_WORDS);

  logic              wrst_q, rrst_q, we;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PTR_W-1:0]  wgray, rgray, wgray_s, rgray_s;
  cxf_word_t         wword, hword;

  cxf_rst_sync u_wrst (.clk(wclk), .arst_n(wrst_n), .rst_n_o(wrst_q));
  cxf_rst_sync u_rrst (.clk(rclk), .arst_n(rrst_n), .rst_n_o(rrst_q));

  cxf_wr_ctl #(.AW(ADDR_W)) u_wr (
    .clk(wclk), .rst_n(wrst_q), .push(wr_en), .rgray_s(rgray_s),
    .waddr(waddr), .wgray(wgray), .we(we), .full(full), .overflow(wr_overflow)
  );

  cxf_gray_sync #(.W(PTR_W)) u_w2r (.clk(rclk), .rst_n(rrst_q), .d(wgray), .q(wgray_s));
  cxf_gray_sync #(.W(PTR_W)) u_r2w (.clk(wclk), .rst_n(wrst_q), .d(rgray), .q(rgray_s));

  cxf_rd_ctl #(.AW(ADDR_W)) u_rd (
    .clk(rclk), .rst_n(rrst_q), .pop(rd_en), .wgray_s(wgray_s),
    .raddr(raddr), .rgray(rgray), .count(rd_count), .empty(empty),
    .underrun(rd_underrun)
  );

  assign wword = '{idle: wr_idle, soc: wr_soc, data: wr_data};

  cxf_mem #(.AW(ADDR_W), .W(WORD_W)) u_mem (
    .wclk(wclk), .we(we), .waddr(waddr), .wdata(wword),
    .raddr(raddr), .rdata(hword)
  );

  assign rd_data    = hword.data;
  assign rd_soc     = hword.soc;
  assign rd_idle    = hword.idle;
  assign cell_ready = ~empty & hword.soc & (rd_count >= CELL_TH);
endmodule

// File: rtl/cxf_checker.sv
module cxf_checker #(
  parameter int PTR_W      = 7,
  parameter int CELL_WORDS = 23
) (
  input logic             wclk,
  input logic             wrst_q,
  input logic             rclk,
  input logic             rrst_q,
  input logic             wr_en,
  input logic             full,
  input logic             wr_overflow,
  input logic             rd_en,
  input logic             empty,
  input logic             rd_underrun,
  input logic             rd_soc,
  input logic             cell_ready,
  input logic [PTR_W-1:0] rd_count
);
  localparam logic [PTR_W-1:0] CELL_TH = PTR_W'(CELL_WORDS);
  localparam logic [PTR_W-1:0] DEPTH   = PTR_W'(1 << (PTR_W - 1));

  a_r3_overflow_set: assert property (@(posedge wclk) disable iff (!wrst_q)
    (wr_en && full) |=> wr_overflow);
  a_r3_overflow_sticky: assert property (@(posedge wclk) disable iff (!wrst_q)
    wr_overflow |=> wr_overflow);
  a_r4_underrun_set: assert property (@(posedge rclk) disable iff (!rrst_q)
    (rd_en && empty) |=> rd_underrun);
  a_r4_underrun_sticky: assert property (@(posedge rclk) disable iff (!rrst_q)
    rd_underrun |=> rd_underrun);
  a_r5_count_bound: assert property (@(posedge rclk) disable iff (!rrst_q)
    rd_count <= DEPTH);
  a_r6_cell_rule: assert property (@(posedge rclk) disable iff (!rrst_q)
    cell_ready |-> (rd_soc && !empty && rd_count >= CELL_TH));
endmodule

bind cell_xfer_fifo cxf_checker #(.PTR_W(ADDR_W + 1), .CELL_WORDS(CELL_WORDS)) u_chk (
  .wclk(wclk), .wrst_q(wrst_q), .rclk(rclk), .rrst_q(rrst_q),
  .wr_en(wr_en), .full(full), .wr_overflow(wr_overflow),
  .rd_en(rd_en), .empty(empty), .rd_underrun(rd_underrun),
  .rd_soc(rd_soc), .cell_ready(cell_ready), .rd_count(rd_count)
);

// File: tb/cell_xfer_fifo_bench.sv
module cell_xfer_fifo_bench;
  logic        wclk = 0, rclk = 0, wrst_n = 0, rrst_n = 0;
  logic        wr_en = 0, wr_soc = 0, wr_idle = 0, rd_en = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        full, wr_overflow, rd_soc, rd_idle, empty, rd_underrun, cell_ready;
  logic [6:0]  rd_count;
  int          total = 0, bad = 0;
  bit          done = 0;

  always #5 wclk = ~wclk;
  always #8 rclk = ~rclk;

  cell_xfer_fifo u_cell_xfer_fifo (.*);

  // bit 33 idle, bit 32 start-of-cell, bits 31:0 data
  localparam logic [33:0] VEC [8] = '{
    {2'b01, 32'h1111_0000}, {2'b00, 32'h2222_0001}, {2'b10, 32'hFFFF_FFFF},
    {2'b11, 32'h0000_0000}, {2'b00, 32'hA5A5_5A5A}, {2'b01, 32'h8000_0001},
    {2'b10, 32'h1234_5678}, {2'b00, 32'hDEAD_BEEF}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [33:0] w);
    @(negedge wclk);
    wr_en = 1; wr_idle = w[33]; wr_soc = w[32]; wr_data = w[31:0];
    @(negedge wclk);
    wr_en = 0;
  endtask

  task automatic pop();
    @(negedge rclk); rd_en = 1;
    @(negedge rclk); rd_en = 0;
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk);
    repeat (6) @(negedge wclk);
    @(negedge rclk);
  endtask

  task automatic do_reset();
    wrst_n = 0; rrst_n = 0;
    repeat (3) @(negedge rclk);
    wrst_n = 1; rrst_n = 1;
    settle();
  endtask

  initial begin
    repeat (100000) @(posedge wclk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 empty", empty, 1); chk("R1 full", full, 0);
    chk("R1 count", rd_count, 0); chk("R1 overflow", wr_overflow, 0);
    chk("R1 underrun", rd_underrun, 0); chk("R1 cell_ready", cell_ready, 0);

    // R2 / R5 table walk
    foreach (VEC[i]) push(VEC[i]);
    settle();
    chk("R5 count after 8", rd_count, 8);
    foreach (VEC[i]) begin
      chk("R2 head word", {rd_idle, rd_soc, rd_data}, VEC[i]);
      pop();
    end
    settle();
    chk("R5 empty after drain", empty, 1);
    chk("R5 count after drain", rd_count, 0);

    // R4 underrun
    pop(); settle();
    chk("R4 underrun set", rd_underrun, 1);
    chk("R4 count unchanged", rd_count, 0);
    push({2'b00, 32'hCAFE_0042}); settle();
    chk("R4 pointer held", {rd_idle, rd_soc, rd_data}, {2'b00, 32'hCAFE_0042});
    chk("R4 underrun sticky", rd_underrun, 1);
    pop(); settle();

    // R8 reset clears flags
    do_reset();
    chk("R8 underrun cleared", rd_underrun, 0);
    chk("R8 empty", empty, 1);

    // R6 cell ready threshold
    for (int i = 0; i < 22; i++) push({1'b0, i == 0, 32'(i)});
    settle();
    chk("R6 not ready at 22", cell_ready, 0);
    push({2'b00, 32'd22}); settle();
    chk("R6 ready at 23", cell_ready, 1);
    pop(); settle();
    chk("R6 head lacks soc", cell_ready, 0);
    chk("R5 count 22", rd_count, 22);
    for (int i = 0; i < 22; i++) pop();
    settle();
    chk("R5 empty again", empty, 1);

    // R3 full and overflow
    for (int i = 0; i < 64; i++) push({2'b00, 32'(i + 256)});
    settle();
    chk("R3 full at 64", full, 1);
    chk("R5 count 64", rd_count, 64);
    chk("R3 no overflow yet", wr_overflow, 0);
    push({2'b11, 32'h0000_DEAD}); settle();
    chk("R3 overflow set", wr_overflow, 1);
    chk("R3 count still 64", rd_count, 64);
    for (int i = 0; i < 64; i++) begin
      chk("R3 drained word", {rd_idle, rd_soc, rd_data}, {2'b00, 32'(i + 256)});
      pop();
      if (i == 0) begin
        settle();
        chk("R7 full released", full, 0);
      end
    end
    settle();
    chk("R3 empty after drop", empty, 1);
    chk("R3 overflow sticky", wr_overflow, 1);
    do_reset();
    chk("R8 overflow cleared", wr_overflow, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule